// File: doc/BRIEF.md
# Staggered Double-Rate Integer ALU

This block is a 32-bit integer unit for the simplest operations: add, subtract, AND, OR and XOR. It runs on a fast clock at twice the core rate. Each operation is split over three fast cycles. The first cycle produces the low half of the result. The second produces the high half, using the carry saved from the low half. The third produces the condition flags. A new operation may be issued on every fast cycle, and a valid bit moves down the pipe beside each operation.

Each half of a result is published as soon as it exists, so a dependent operation can follow its producer on the very next fast cycle. A dependent operation asks for the previous result through a per-operand bypass select. It picks up the producer's low half in its own first cycle and the producer's high half in its own second cycle. Those are exactly the cycles in which each half is needed. Multiply, shift, rotate and branch resolution are not handled here.

Top module: `staggered_alu`

## Requirements
- R1: A synchronous active-high reset clears `lo_valid`, `hi_valid` and `out_valid` at the next clock edge and holds them low while asserted.
- R2: An operation issued with `in_valid` high in cycle t shows `lo_valid` high and result bits 15:0 on `lo_res` in cycle t+1.
- R3: In cycle t+2 the same operation shows `hi_valid` high and result bits 31:16 on `hi_res`, including the carry out of the low half (for example 0x0000FFFF + 1 gives high half 0x0001).
- R4: In cycle t+3 `out_valid` is high, `out_result` holds the full 32-bit result and `out_flags` holds bit 0 = zero, bit 1 = carry, bit 2 = sign (result bit 31), bit 3 = signed overflow.
- R5: Opcode 0 adds. Opcode 1 subtracts as a + ~b + 1, and its carry flag is the carry out of that sum (1 when a >= b unsigned). For both, overflow is set when the operands entering the adder have equal sign bits and the result sign differs from them.
- R6: Opcodes 2, 3 and 4 give AND, OR and XOR. For these, carry and overflow are 0, while zero and sign follow the result.
- R7: When `in_fwd_a` (or `in_fwd_b`) is high, that operand is replaced by the result of the operation issued in the previous cycle. Its low half comes from that op's first-stage output and its high half from its second-stage output. This lets dependent ops run back to back on every fast cycle.
- R8: Operations may be issued on consecutive cycles with no gap. A cycle with `in_valid` low produces no valid output at any stage three, two or one cycles later.
- R9: The unused opcodes 5, 6 and 7 behave as add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (twice the core rate) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_op | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor, others add |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_fwd_a | input | 1 | Take operand a from the previous op's result |
| in_fwd_b | input | 1 | Take operand b from the previous op's result |
| lo_valid | output | 1 | `lo_res` is valid |
| lo_res | output | 16 | Low result half, one cycle after issue |
| hi_valid | output | 1 | `hi_res` is valid |
| hi_res | output | 16 | High result half, two cycles after issue |
| out_valid | output | 1 | Full result and flags are valid |
| out_result | output | 32 | Full result, three cycles after issue |
| out_flags | output | 4 | {overflow, sign, carry, zero} |

## Verification
With a back-to-back dependent pair, two things happen in the same fast cycle. The second stage selects the producer's high half from its own output register. At the same time, the first stage builds the consumer's low half from the producer's low-half register. The bench provokes this with chains of forwarded adds and subtracts whose carries cross bit 15 and bit 31. Each half is judged on the cycle it appears on its own output, against a model of the result that the bench computes from the requirements. A one-cycle mistake in either bypass alignment therefore shows up as a wrong half at its own stage.

// File: rtl/salu_pkg.sv
package salu_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;

  function automatic logic op_is_logic(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/salu_lo_stage.sv
module salu_lo_stage import salu_pkg::*; #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [HW-1:0] a_lo,
  input  logic [HW-1:0] b_lo,
  input  logic [HW-1:0] a_hi,
  input  logic [HW-1:0] b_hi,
  input  logic          fwd_a,
  input  logic          fwd_b,
  output logic          s1_valid,
  output logic [2:0]    s1_op,
  output logic [HW-1:0] s1_lo,
  output logic          s1_carry,
  output logic [HW-1:0] s1_a_hi,
  output logic [HW-1:0] s1_b_hi,
  output logic          s1_fwd_a,
  output logic          s1_fwd_b
);
  logic [HW-1:0] opa, opb, opb_x, res;
  logic [HW:0]   sum;
  logic          sub;

  always_comb begin
    // low-half bypass comes straight from this stage's own register
    opa   = fwd_a ? s1_lo : a_lo;
    opb   = fwd_b ? s1_lo : b_lo;
    sub   = (in_op == OP_SUB);
    opb_x = sub ? ~opb : opb;
    sum   = {1'b0, opa} + {1'b0, opb_x} + {{HW{1'b0}}, sub};
    case (in_op)
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      default: res = sum[HW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_ADD;
      s1_lo    <= '0;
      s1_carry <= 1'b0;
      s1_a_hi  <= '0;
      s1_b_hi  <= '0;
      s1_fwd_a <= 1'b0;
      s1_fwd_b <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_op    <= in_op;
      s1_lo    <= res;
      s1_carry <= op_is_logic(in_op) ? 1'b0 : sum[HW];
      s1_a_hi  <= a_hi;
      s1_b_hi  <= b_hi;
      s1_fwd_a <= fwd_a;
      s1_fwd_b <= fwd_b;
    end
  end
endmodule

// File: rtl/salu_hi_stage.sv
module salu_hi_stage import salu_pkg::*; #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_valid,
  input  logic [2:0]    s1_op,
  input  logic [HW-1:0] s1_lo,
  input  logic          s1_carry,
  input  logic [HW-1:0] s1_a_hi,
  input  logic [HW-1:0] s1_b_hi,
  input  logic          s1_fwd_a,
  input  logic          s1_fwd_b,
  output logic          s2_valid,
  output logic          s2_logic,
  output logic [HW-1:0] s2_lo,
  output logic [HW-1:0] s2_hi,
  output logic          s2_carry,
  output logic          s2_ovf
);
  logic [HW-1:0] opa, opb, opb_x, res;
  logic [HW:0]   sum;
  logic          sub, ovf;

  always_comb begin
    // high-half bypass: the producer sits one stage ahead, in this register
    opa   = s1_fwd_a ? s2_hi : s1_a_hi;
    opb   = s1_fwd_b ? s2_hi : s1_b_hi;
    sub   = (s1_op == OP_SUB);
    opb_x = sub ? ~opb : opb;
    sum   = {1'b0, opa} + {1'b0, opb_x} + {{HW{1'b0}}, s1_carry};
    ovf   = (opa[HW-1] == opb_x[HW-1]) && (sum[HW-1] != opa[HW-1]);
    case (s1_op)
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      default: res = sum[HW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_logic <= 1'b0;
      s2_lo    <= '0;
      s2_hi    <= '0;
      s2_carry <= 1'b0;
      s2_ovf   <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      s2_logic <= op_is_logic(s1_op);
      s2_lo    <= s1_lo;
      s2_hi    <= res;
      s2_carry <= sum[HW];
      s2_ovf   <= ovf;
    end
  end
endmodule

// File: rtl/salu_flag_stage.sv
module salu_flag_stage import salu_pkg::*; #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s2_valid,
  input  logic            s2_logic,
  input  logic [HW-1:0]   s2_lo,
  input  logic [HW-1:0]   s2_hi,
  input  logic            s2_carry,
  input  logic            s2_ovf,
  output logic            s3_valid,
  output logic [2*HW-1:0] s3_result,
  output logic [FLG_W-1:0] s3_flags
);
  logic [FLG_W-1:0] flg;

  always_comb begin
    flg        = '0;
    flg[FLG_Z] = ({s2_hi, s2_lo} == '0);
    flg[FLG_N] = s2_hi[HW-1];
    flg[FLG_C] = s2_logic ? 1'b0 : s2_carry;
    flg[FLG_V] = s2_logic ? 1'b0 : s2_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid  <= 1'b0;
      s3_result <= '0;
      s3_flags  <= '0;
    end else begin
      s3_valid  <= s2_valid;
      s3_result <= {s2_hi, s2_lo};
      s3_flags  <= flg;
    end
  end
endmodule

// File: rtl/staggered_alu.sv
module staggered_alu import salu_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          in_fwd_a,
  input  logic          in_fwd_b,
  output logic          lo_valid,
  output logic [DW/2-1:0] lo_res,
  output logic          hi_valid,
  output logic [DW/2-1:0] hi_res,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic [3:0]    out_flags
);
  localparam int HW = DW / 2;

  logic          s1_valid, s1_carry, s1_fwd_a, s1_fwd_b;
  logic [2:0]    s1_op;
  logic [HW-1:0] s1_lo, s1_a_hi, s1_b_hi;
  logic          s2_valid, s2_logic, s2_carry, s2_ovf;
  logic [HW-1:0] s2_lo, s2_hi;

  salu_lo_stage #(.HW(HW)) lo_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .a_lo(in_a[HW-1:0]), .b_lo(in_b[HW-1:0]),
    .a_hi(in_a[DW-1:HW]), .b_hi(in_b[DW-1:HW]),
    .fwd_a(in_fwd_a), .fwd_b(in_fwd_b),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_lo(s1_lo), .s1_carry(s1_carry),
    .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi), .s1_fwd_a(s1_fwd_a), .s1_fwd_b(s1_fwd_b)
  );

  salu_hi_stage #(.HW(HW)) hi_i (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_op(s1_op), .s1_lo(s1_lo),
    .s1_carry(s1_carry), .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi),
    .s1_fwd_a(s1_fwd_a), .s1_fwd_b(s1_fwd_b),
    .s2_valid(s2_valid), .s2_logic(s2_logic), .s2_lo(s2_lo), .s2_hi(s2_hi),
    .s2_carry(s2_carry), .s2_ovf(s2_ovf)
  );

  salu_flag_stage #(.HW(HW)) flg_i (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_logic(s2_logic),
    .s2_lo(s2_lo), .s2_hi(s2_hi), .s2_carry(s2_carry), .s2_ovf(s2_ovf),
    .s3_valid(out_valid), .s3_result(out_result), .s3_flags(out_flags)
  );

  assign lo_valid = s1_valid;
  assign lo_res   = s1_lo;
  assign hi_valid = s2_valid;
  assign hi_res   = s2_hi;
endmodule

// File: rtl/staggered_alu_chk.sv
module staggered_alu_chk import salu_pkg::*; #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic          in_fwd_a,
  input logic          in_fwd_b,
  input logic          lo_valid,
  input logic [DW/2-1:0] lo_res,
  input logic          hi_valid,
  input logic [DW/2-1:0] hi_res,
  input logic          out_valid,
  input logic [DW-1:0] out_result,
  input logic [3:0]    out_flags
);
  localparam int HW = DW / 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!lo_valid && !hi_valid && !out_valid));

  a_r2_lo_follows_issue: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> lo_valid);

  a_r8_idle_no_lo: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !lo_valid);

  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
    lo_valid |=> hi_valid);

  a_r4_hi_kept_in_result: assert property (@(posedge clk) disable iff (rst)
    hi_valid |=> (out_valid && out_result[DW-1:HW] == $past(hi_res)));

  a_r4_lo_kept_in_result: assert property (@(posedge clk) disable iff (rst)
    lo_valid |=> ##1 (out_result[HW-1:0] == $past(lo_res, 2)));

  a_r6_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_logic(in_op)) |-> ##3
      (!out_flags[FLG_C] && !out_flags[FLG_V]));

  a_r5_sub_equal_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SUB && in_a == in_b && !in_fwd_a && !in_fwd_b)
      |-> ##3 (out_flags[FLG_Z] && out_flags[FLG_C]));
endmodule

bind staggered_alu staggered_alu_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
  .in_b(in_b), .in_fwd_a(in_fwd_a), .in_fwd_b(in_fwd_b),
  .lo_valid(lo_valid), .lo_res(lo_res), .hi_valid(hi_valid), .hi_res(hi_res),
  .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags)
);

// File: tb/staggered_alu_tb_top.sv
module staggered_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_fwd_a = 1'b0, in_fwd_b = 1'b0;
  logic        lo_valid, hi_valid, out_valid;
  logic [15:0] lo_res, hi_res;
  logic [31:0] out_result;
  logic [3:0]  out_flags;

  int checks = 0;
  int failures = 0;

  // expected pipeline: index 1 = issued one cycle ago, etc.
  bit          e_v   [1:3];
  logic [31:0] e_res [1:3];
  logic [3:0]  e_flg [1:3];
  string       e_tag [1:3];
  logic [31:0] prev_res = '0;

  always #5 clk = ~clk;

  staggered_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .in_fwd_a(in_fwd_a), .in_fwd_b(in_fwd_b),
    .lo_valid(lo_valid), .lo_res(lo_res), .hi_valid(hi_valid), .hi_res(hi_res),
    .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags)
  );

  // flags packed {V,N,C,Z} above the 32-bit result
  function automatic logic [35:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    logic [31:0] bx, r;
    logic c, v;
    c = 1'b0; v = 1'b0;
    case (op)
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: begin
        bx = (op == 3'd1) ? ~b : b;
        s  = {1'b0, a} + {1'b0, bx} + {32'd0, (op == 3'd1)};
        r  = s[31:0];
        c  = s[32];
        v  = (a[31] == bx[31]) && (r[31] != a[31]);
      end
    endcase
    return {v, r[31], c, (r == 32'd0), r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(lo_valid == e_v[1], {"R8 lo_valid ", e_tag[1]}, 32'(lo_valid), 32'(e_v[1]));
    chk(hi_valid == e_v[2], {"R8 hi_valid ", e_tag[2]}, 32'(hi_valid), 32'(e_v[2]));
    chk(out_valid == e_v[3], {"R8 out_valid ", e_tag[3]}, 32'(out_valid), 32'(e_v[3]));
    if (e_v[1]) chk(lo_res == e_res[1][15:0], {"R2 lo_res ", e_tag[1]}, 32'(lo_res), 32'(e_res[1][15:0]));
    if (e_v[2]) chk(hi_res == e_res[2][31:16], {"R3 hi_res ", e_tag[2]}, 32'(hi_res), 32'(e_res[2][31:16]));
    if (e_v[3]) begin
      chk(out_result == e_res[3], {"R4 out_result ", e_tag[3]}, out_result, e_res[3]);
      chk(out_flags == e_flg[3], {"R4 out_flags ", e_tag[3]}, 32'(out_flags), 32'(e_flg[3]));
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input bit fa, input bit fb, input string tag);
    logic [31:0] ea, eb;
    logic [35:0] m;
    @(negedge clk);
    check_outputs();
    ea = fa ? prev_res : a;
    eb = fb ? prev_res : b;
    m  = model(op, ea, eb);
    in_valid = v; in_op = op; in_a = a; in_b = b; in_fwd_a = fa; in_fwd_b = fb;
    e_v[3] = e_v[2]; e_res[3] = e_res[2]; e_flg[3] = e_flg[2]; e_tag[3] = e_tag[2];
    e_v[2] = e_v[1]; e_res[2] = e_res[1]; e_flg[2] = e_flg[1]; e_tag[2] = e_tag[1];
    e_v[1] = v; e_res[1] = m[31:0]; e_flg[1] = m[35:32]; e_tag[1] = tag;
    if (v) prev_res = m[31:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 32'd0, 1'b0, 1'b0, "idle");
  endtask

  task automatic clear_model();
    for (int i = 1; i <= 3; i++) begin
      e_v[i] = 1'b0; e_res[i] = '0; e_flg[i] = '0; e_tag[i] = "reset";
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    clear_model();
    repeat (3) @(negedge clk);
    chk(!lo_valid && !hi_valid && !out_valid, "R1 valids low in reset",
        {29'd0, lo_valid, hi_valid, out_valid}, 32'd0);
    rst = 1'b0;
    // reset in the middle of a stream
    step(1'b1, 3'd0, 32'd1, 32'd2, 1'b0, 1'b0, "R1");
    step(1'b1, 3'd0, 32'd3, 32'd4, 1'b0, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(!lo_valid && !hi_valid && !out_valid, "R1 valids cleared mid-stream",
        {29'd0, lo_valid, hi_valid, out_valid}, 32'd0);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic t_add();
    step(1'b1, 3'd0, 32'h1234_5678, 32'h1111_1111, 1'b0, 1'b0, "R5 add plain");
    step(1'b1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R3 carry across halves");
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R5 carry out, zero");
    step(1'b1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R5 add overflow");
    idle(3);
  endtask

  task automatic t_sub();
    step(1'b1, 3'd1, 32'd5, 32'd7, 1'b0, 1'b0, "R5 sub borrow");
    step(1'b1, 3'd1, 32'h8000_0000, 32'd1, 1'b0, 1'b0, "R5 sub overflow");
    step(1'b1, 3'd1, 32'hABCD_0000, 32'hABCD_0000, 1'b0, 1'b0, "R5 sub equal");
    step(1'b1, 3'd1, 32'h0001_0000, 32'h0000_0001, 1'b0, 1'b0, "R5 sub borrow across halves");
    idle(3);
  endtask

  task automatic t_logic();
    step(1'b1, 3'd2, 32'hFFFF_0F0F, 32'h8000_FFFF, 1'b0, 1'b0, "R6 and");
    step(1'b1, 3'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R6 or zero");
    step(1'b1, 3'd4, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R6 xor");
    idle(3);
  endtask

  task automatic t_forward();
    step(1'b1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R7 producer");
    step(1'b1, 3'd0, 32'hDEAD_BEEF, 32'h0000_FFFF, 1'b1, 1'b0, "R7 fwd a");
    step(1'b1, 3'd1, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R7 fwd a and b");
    step(1'b1, 3'd1, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, "R7 fwd b sub");
    step(1'b1, 3'd4, 32'h5555_AAAA, 32'h0000_0000, 1'b0, 1'b1, "R7 fwd b xor");
    step(1'b1, 3'd0, 32'h0000_0000, 32'h8001_8001, 1'b1, 1'b0, "R7 fwd a add carry");
    idle(3);
  endtask

  task automatic t_bubbles();
    step(1'b1, 3'd0, 32'd10, 32'd20, 1'b0, 1'b0, "R8 before gap");
    idle(1);
    step(1'b1, 3'd3, 32'hF000_000F, 32'h0F00_00F0, 1'b0, 1'b0, "R8 after gap");
    idle(2);
    step(1'b1, 3'd5, 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b0, "R9 code 5");
    step(1'b1, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 code 7");
    idle(3);
  endtask

  initial begin
    #(10 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_forward();
    t_bubbles();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule